// File: doc/BRIEF.md
# DSP DMA Instruction Sequencer

This block decodes the DMA-class instructions of a small signal processor and carries out the transfers they describe. Data moves between a 32-bit external port and one of four local data RAMs, or into the program RAM. The block owns three pieces of state: the external address register, the remaining word count and the busy flag. An instruction sets the direction, the source of the word count, the address step and whether hold mode is used.

The word count comes from one of two places. It can be an 8-bit immediate field. It can also be read from a data RAM chosen by a 3-bit selector, and that read can post-increment the RAM's pointer. Each external beat uses a valid/ready handshake, and the block stalls without losing state while ready is low. When the narrow (16-bit) bus is selected, an outbound 32-bit word leaves as two beats, upper half first, and the address steps between the halves. In hold mode the address and count registers go back to their start values once the transfer ends.

A transfer ends when the count runs out. It can also end early when a forced-stop or end-of-transfer strobe arrives. Either strobe takes effect when the current word completes.

Top module: `dsp_dma_seq`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high, the block is idle, and `instr[31:28]` equals 1100. Any other opcode, and any instruction offered while busy, leaves the block idle or leaves the running transfer unchanged.
- R2: Out of reset, `busy`, `ext_valid`, `step_err`, `words_left` and `ext_addr` are 0. `busy` is high from the cycle after acceptance until one closing cycle after the last beat, and no bus or RAM strobe is active while `busy` is low.
- R3: With `instr[13]`=0 the count is `instr[7:0]`. An immediate count of 0 produces no bus beat, and `busy` falls two cycles after acceptance.
- R4: With `instr[13]`=1 the count is read, in the cycle after acceptance, from data RAM `instr[1:0]`. `ptr_inc` then pulses the bit for that RAM only if `instr[2]` is 1; otherwise no pointer strobe occurs.
- R5: With `instr[12]`=1 RAM words go out as external writes, and each finished word pulses `ram_rd_adv`. With `instr[12]`=0 external reads are made, and each returned word is written to the target RAM through `ram_we` and `ram_wdata`.
- R6: The step code `instr[17:15]` gives steps 0, 1, 2, 4, 8, 16, 32 and 64 for codes 0 to 7. `ext_addr` advances by the step after every accepted beat.
- R7: In inbound forms that take the count from RAM, and in inbound hold forms, only `instr[15]` sets the step (0 or 1), and `instr[10:8]` names the target: values 0 to 3 give data RAM 0 to 3 and a set bit 10 gives the program RAM (`ram_sel`=4). All other forms take the target from `instr[9:8]`.
- R8: On the wide bus (`narrow_bus`=0 at acceptance) a step code above 1 sets `step_err` and uses step 1. `step_err` keeps its value until the next accepted instruction.
- R9: On the narrow bus an outbound word is sent as two beats, upper 16 bits first. Each half travels in `ext_wdata[15:0]` with `ext_wdata[31:16]`=0. Inbound beats are always whole 32-bit words.
- R10: `words_left` falls by one per completed 32-bit word. The transfer ends after the word that takes it to 0.
- R11: With `instr[14]`=1, once the transfer ends `ext_addr` and `words_left` return to their values at the start of the transfer.
- R12: While `ext_valid` is high and `ext_ready` is low, `ext_valid` stays high and `ext_addr` is unchanged.
- R13: A pulse on `force_stop` or `ext_end` ends the transfer when the word in progress completes. `ext_addr` and `words_left` then keep the values left by that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr | input | 32 | Instruction word |
| narrow_bus | input | 1 | 1 selects the 16-bit external bus |
| addr_load | input | 1 | Load `addr_value` into the address register while idle |
| addr_value | input | AW | New external address |
| ram_rdata | input | 32 | Read data of RAM `ram_sel` at its pointer |
| ext_ready | input | 1 | External side accepts the beat |
| ext_rdata | input | 32 | External read data |
| ext_end | input | 1 | External end-of-transfer strobe |
| force_stop | input | 1 | Forced stop strobe |
| busy | output | 1 | Busy flag |
| step_err | output | 1 | Illegal step on the wide bus |
| words_left | output | CW | Remaining word count register |
| ram_sel | output | 3 | RAM select, 0-3 data RAMs, 4 program RAM |
| ram_we | output | 1 | RAM write strobe, pointer advances |
| ram_wdata | output | 32 | RAM write data |
| ram_rd_adv | output | 1 | RAM word consumed, pointer advances |
| ptr_inc | output | 4 | Pointer increment strobes for the count read |
| ext_valid | output | 1 | External beat valid |
| ext_write | output | 1 | Beat is a write |
| ext_addr | output | AW | External address register |
| ext_wdata | output | 32 | External write data |

## Verification
The assertions assume the RAM read data stays constant while a beat waits for ready, which holds because the RAM pointer moves only on the block's own strobes. They also assume that `addr_load` is used only while idle. The bench's RAM model moves pointers only after the clock edge that carries `ram_we`, `ram_rd_adv` or `ptr_inc`. Its stimulus loads addresses only between transfers and holds `narrow_bus` constant for the whole of each transfer.

// File: rtl/dsp_dma_pkg.sv
package dsp_dma_pkg;

  localparam logic [3:0] DMA_OPCODE = 4'b1100;
  localparam int         STEP_W     = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CNT,
    ST_XFER,
    ST_END
  } dma_state_e;

  typedef struct packed {
    logic              is_dma;
    logic              indirect;
    logic              dir_out;
    logic              hold;
    logic [2:0]        tgt;
    logic [2:0]        cnt_src;
    logic [7:0]        imm;
    logic [STEP_W-1:0] step;
    logic              step_err;
  } dma_dec_t;

endpackage

// File: rtl/dsp_dma_decode.sv
module dsp_dma_decode
  import dsp_dma_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        narrow_bus,
  output dma_dec_t    dec
);

  logic       short_form;
  logic [2:0] code;

  always_comb begin
    // inbound forms with a RAM count, and inbound hold forms, use the short layout
    short_form   = !instr[12] && (instr[13] || instr[14]);
    code         = short_form ? {2'b00, instr[15]} : instr[17:15];
    dec.is_dma   = (instr[31:28] == DMA_OPCODE);
    dec.indirect = instr[13];
    dec.dir_out  = instr[12];
    dec.hold     = instr[14];
    if (short_form) dec.tgt = instr[10] ? 3'd4 : {1'b0, instr[9:8]};
    else            dec.tgt = {1'b0, instr[9:8]};
    dec.cnt_src  = instr[2:0];
    dec.imm      = instr[7:0];
    dec.step_err = 1'b0;
    if (code == 3'd0) begin
      dec.step = '0;
    end else if (!narrow_bus && code > 3'd1) begin
      dec.step     = STEP_W'(1);
      dec.step_err = 1'b1;
    end else begin
      dec.step = STEP_W'(1) << (code - 3'd1);
    end
  end

endmodule

// File: rtl/dsp_dma_regs.sv
module dsp_dma_regs #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_value,
  input  logic          snap,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_value,
  input  logic          addr_adv,
  input  logic [SW-1:0] step,
  input  logic          cnt_dec,
  input  logic          restore,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q
);

  logic [AW-1:0] addr_d, base_addr_q, base_addr_d;
  logic [CW-1:0] cnt_d, base_cnt_q, base_cnt_d;

  always_comb begin
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (addr_load) addr_d = addr_value;
    if (snap)      base_addr_d = addr_q;
    if (cnt_load) begin
      cnt_d      = cnt_value;
      base_cnt_d = cnt_value;
    end
    if (addr_adv) addr_d = addr_q + AW'(step);
    if (cnt_dec)  cnt_d  = cnt_q - CW'(1);
    if (restore) begin
      addr_d = base_addr_q;
      cnt_d  = base_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      cnt_q       <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else begin
      addr_q      <= addr_d;
      cnt_q       <= cnt_d;
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
    end
  end

  // R10: the sequencer never decrements an exhausted count
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> (cnt_q != '0));

endmodule

// File: rtl/dsp_dma_seq.sv
module dsp_dma_seq
  import dsp_dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [31:0]   instr,
  input  logic          narrow_bus,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_value,
  input  logic [31:0]   ram_rdata,
  input  logic          ext_ready,
  input  logic [31:0]   ext_rdata,
  input  logic          ext_end,
  input  logic          force_stop,
  output logic          busy,
  output logic          step_err,
  output logic [CW-1:0] words_left,
  output logic [2:0]    ram_sel,
  output logic          ram_we,
  output logic [31:0]   ram_wdata,
  output logic          ram_rd_adv,
  output logic [3:0]    ptr_inc,
  output logic          ext_valid,
  output logic          ext_write,
  output logic [AW-1:0] ext_addr,
  output logic [31:0]   ext_wdata
);

  localparam int HW = 16;

  logic       rst_meta_q, rst_sync_n;
  dma_dec_t   dec, op_q, op_d;
  dma_state_e state_q, state_d;
  logic       narrow_q, narrow_d, half_q, half_d, stop_q, stop_d, err_q, err_d;
  logic       snap, cnt_ld, addr_adv, cnt_dec, restore, stop_now, last_beat, start;
  logic [CW-1:0] cnt_val;

  // reset asserts asynchronously and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  dsp_dma_decode u_decode (
    .instr      (instr),
    .narrow_bus (narrow_bus),
    .dec        (dec)
  );

  dsp_dma_regs #(.AW(AW), .CW(CW), .SW(STEP_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_load  (addr_load && (state_q == ST_IDLE) && !start),
    .addr_value (addr_value),
    .snap       (snap),
    .cnt_load   (cnt_ld),
    .cnt_value  (cnt_val),
    .addr_adv   (addr_adv),
    .step       (op_q.step),
    .cnt_dec    (cnt_dec),
    .restore    (restore),
    .addr_q     (ext_addr),
    .cnt_q      (words_left)
  );

  assign start     = instr_valid && dec.is_dma;
  assign stop_now  = force_stop || ext_end;
  assign last_beat = !(op_q.dir_out && narrow_q) || half_q;

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    narrow_d   = narrow_q;
    half_d     = half_q;
    stop_d     = stop_q;
    err_d      = err_q;
    snap       = 1'b0;
    cnt_ld     = 1'b0;
    cnt_val    = '0;
    addr_adv   = 1'b0;
    cnt_dec    = 1'b0;
    restore    = 1'b0;
    ram_we     = 1'b0;
    ram_rd_adv = 1'b0;
    ptr_inc    = '0;
    ext_valid  = 1'b0;
    ram_sel    = op_q.tgt;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          op_d     = dec;
          narrow_d = narrow_bus;
          err_d    = dec.step_err;
          stop_d   = 1'b0;
          half_d   = 1'b0;
          snap     = 1'b1;
          if (dec.indirect) begin
            state_d = ST_CNT;
          end else begin
            cnt_ld  = 1'b1;
            cnt_val = CW'(dec.imm);
            state_d = (dec.imm == 8'd0) ? ST_END : ST_XFER;
          end
        end
      end
      ST_CNT: begin
        ram_sel = {1'b0, op_q.cnt_src[1:0]};
        ptr_inc[op_q.cnt_src[1:0]] = op_q.cnt_src[2];
        cnt_ld  = 1'b1;
        cnt_val = ram_rdata[CW-1:0];
        state_d = (cnt_val == '0 || stop_q || stop_now) ? ST_END : ST_XFER;
      end
      ST_XFER: begin
        ext_valid = 1'b1;
        stop_d    = stop_q || stop_now;
        if (ext_ready) begin
          addr_adv = 1'b1;
          if (last_beat) begin
            half_d     = 1'b0;
            cnt_dec    = 1'b1;
            ram_we     = !op_q.dir_out;
            ram_rd_adv = op_q.dir_out;
            if (words_left == CW'(1) || stop_q || stop_now) state_d = ST_END;
          end else begin
            half_d = 1'b1;
          end
        end
      end
      ST_END: begin
        restore = op_q.hold;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      narrow_q <= 1'b0;
      half_q   <= 1'b0;
      stop_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      narrow_q <= narrow_d;
      half_q   <= half_d;
      stop_q   <= stop_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    if (!op_q.dir_out)  ext_wdata = '0;
    else if (!narrow_q) ext_wdata = ram_rdata;
    else if (!half_q)   ext_wdata = {{HW{1'b0}}, ram_rdata[31:HW]};
    else                ext_wdata = {{HW{1'b0}}, ram_rdata[HW-1:0]};
  end

  assign ext_write = ext_valid && op_q.dir_out;
  assign ram_wdata = ext_rdata;
  assign busy      = (state_q != ST_IDLE);
  assign step_err  = err_q;

  // R1: nothing but an accepted DMA opcode leaves the idle state
  assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> !busy);
  // R2: acceptance raises the busy flag on the next cycle
  assert_busy_rises_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start) |=> busy);
  // R2: no strobes while idle
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!ext_valid && !ram_we && !ram_rd_adv && ptr_inc == 4'd0));
  // R3: zero immediate count closes without any beat
  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && start && !dec.indirect && dec.imm == 8'd0) |=> (busy && !ext_valid) ##1 !busy);
  // R4: at most one pointer strobe at a time
  assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ptr_inc));
  // R8: the wide bus never steps by more than one
  assert_wide_step_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_valid && ext_ready && !narrow_q) |=> ((ext_addr - $past(ext_addr)) <= AW'(1)));
  // R12: a waiting beat is held with a stable address
  assert_beat_held_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr)));

endmodule

// File: tb/dsp_dma_seq_tb.sv
module dsp_dma_seq_tb;
  localparam int AW = 24;
  localparam int CW = 16;

  typedef struct packed {logic wr; logic [AW-1:0] a; logic [31:0] d;} bus_t;
  typedef struct packed {logic [2:0] sel; logic [31:0] d;} ramw_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          instr_valid = 1'b0, narrow_bus = 1'b0, addr_load = 1'b0;
  logic [31:0]   instr = '0;
  logic [AW-1:0] addr_value = '0;
  logic [31:0]   ram_rdata, ext_rdata;
  logic          ext_ready = 1'b1, ext_end = 1'b0, force_stop = 1'b0;
  logic          busy, step_err, ram_we, ram_rd_adv, ext_valid, ext_write;
  logic [CW-1:0] words_left;
  logic [2:0]    ram_sel;
  logic [31:0]   ram_wdata, ext_wdata;
  logic [3:0]    ptr_inc;
  logic [AW-1:0] ext_addr;

  dsp_dma_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .narrow_bus(narrow_bus), .addr_load(addr_load), .addr_value(addr_value),
    .ram_rdata(ram_rdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
    .ext_end(ext_end), .force_stop(force_stop), .busy(busy), .step_err(step_err),
    .words_left(words_left), .ram_sel(ram_sel), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rd_adv(ram_rd_adv), .ptr_inc(ptr_inc), .ext_valid(ext_valid),
    .ext_write(ext_write), .ext_addr(ext_addr), .ext_wdata(ext_wdata)
  );

  int compared = 0, mismatched = 0;
  logic [31:0] mem [0:7][0:15];
  int ptr [0:7];
  bus_t  exp_bus[$];
  ramw_t exp_ram[$];
  logic [3:0] exp_ptr[$];
  bit rdy_force = 1'b0, rdy_val = 1'b1, rdy_mode = 1'b0;
  int cyc = 0;

  always_comb ram_rdata = mem[ram_sel][ptr[ram_sel] % 16];
  assign ext_rdata = {8'hC3, ext_addr};

  always @(negedge clk) begin
    cyc++;
    ext_ready = rdy_force ? rdy_val : (rdy_mode ? (cyc % 3 != 0) : 1'b1);
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // per-clock monitor: observe before the edge, update the RAM model after it
  initial begin
    bus_t e; ramw_t r; logic [3:0] pi;
    bit p_we, p_adv; int p_sel; logic [31:0] p_d; logic [3:0] p_inc;
    forever begin
      @(negedge clk); #1;
      p_we = 0; p_adv = 0; p_inc = '0; p_sel = 0; p_d = '0;
      if (rst_n) begin
        if (!busy) chk("R2 idle has no beat", 64'(ext_valid), 64'd0);
        if (ext_valid && ext_ready) begin
          if (exp_bus.size() == 0) chk("R5 unexpected beat", 64'(ext_addr), 64'hFFFF_FFFF);
          else begin
            e = exp_bus.pop_front();
            if (e.wr) chk("R6 R9 write beat", {7'd0, ext_write, ext_addr, ext_wdata}, {7'd0, e});
            else      chk("R6 read beat", {39'd0, ext_write, ext_addr}, {39'd0, e.wr, e.a});
          end
        end
        if (ram_we) begin
          if (exp_ram.size() == 0) chk("R5 unexpected RAM write", 64'(ram_sel), 64'hFF);
          else begin
            r = exp_ram.pop_front();
            chk("R5 R7 RAM write", {29'd0, ram_sel, ram_wdata}, {29'd0, r});
          end
          p_we = 1; p_sel = int'(ram_sel); p_d = ram_wdata;
        end
        if (ram_rd_adv) begin p_adv = 1; p_sel = int'(ram_sel); end
        if (ptr_inc != 4'd0) begin
          if (exp_ptr.size() == 0) chk("R4 unexpected pointer strobe", 64'(ptr_inc), 64'd0);
          else begin pi = exp_ptr.pop_front(); chk("R4 pointer strobe", 64'(ptr_inc), 64'(pi)); end
          p_inc = ptr_inc;
        end
      end
      @(posedge clk); #1;
      if (p_we) begin mem[p_sel][ptr[p_sel] % 16] = p_d; ptr[p_sel]++; end
      if (p_adv) ptr[p_sel]++;
      for (int i = 0; i < 4; i++) if (p_inc[i]) ptr[i]++;
    end
  end

  initial begin
    #(4 * 150000);
    compared++; mismatched++;
    $display("FAIL R10 watchdog act=running exp=finished");
    finish_run();
  end

  function automatic logic [31:0] enc(bit hold, bit ind, bit dout, logic [2:0] st,
                                      logic [2:0] tgt, logic [7:0] low);
    logic [31:0] w;
    w = 32'hC000_0000;
    w[17:15] = st; w[14] = hold; w[13] = ind; w[12] = dout; w[10:8] = tgt; w[7:0] = low;
    return w;
  endfunction

  task automatic issue(logic [31:0] w);
    @(negedge clk); instr = w; instr_valid = 1'b1;
    @(negedge clk); instr_valid = 1'b0;
  endtask

  task automatic set_addr(logic [AW-1:0] a);
    @(negedge clk); addr_load = 1'b1; addr_value = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 2000);
    #1;
  endtask

  task automatic exp_out(int r, logic [AW-1:0] a0, int st, int n, bit nar);
    logic [AW-1:0] a = a0; logic [31:0] w;
    for (int k = 0; k < n; k++) begin
      w = mem[r][(ptr[r] + k) % 16];
      if (nar) begin
        exp_bus.push_back({1'b1, a, 16'h0, w[31:16]}); a += AW'(st);
        exp_bus.push_back({1'b1, a, 16'h0, w[15:0]});  a += AW'(st);
      end else begin
        exp_bus.push_back({1'b1, a, w}); a += AW'(st);
      end
    end
  endtask

  task automatic exp_in(int r, logic [AW-1:0] a0, int st, int n);
    logic [AW-1:0] a = a0;
    for (int k = 0; k < n; k++) begin
      exp_bus.push_back({1'b0, a, 32'h0});
      exp_ram.push_back({3'(r), 8'hC3, a});
      a += AW'(st);
    end
  endtask

  task automatic end_check(string req, logic [AW-1:0] a, logic [CW-1:0] c);
    chk(req, {24'd0, ext_addr, words_left}, {24'd0, a, c});
    chk("R10 all beats seen", 64'(exp_bus.size() + exp_ram.size() + exp_ptr.size()), 64'd0);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      ptr[r] = 0;
      for (int i = 0; i < 16; i++) mem[r][i] = 32'((r + 1) << 28) | 32'(i * 257) | 32'h00AB_0000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset state", {59'd0, busy, ext_valid, step_err, 2'b00}, 64'd0);
    chk("R2 reset registers", {24'd0, ext_addr, words_left}, 64'd0);

    // R5 R6 R10: outbound, wide, step code 1, three words from RAM1
    set_addr(24'h100); exp_out(1, 24'h100, 1, 3, 0);
    issue(enc(0, 0, 1, 3'd1, 3'd1, 8'd3)); wait_idle();
    end_check("R10 outbound end regs", 24'h103, 0);

    // R5 R6: inbound, step code 0, ready pattern, into RAM2
    rdy_mode = 1'b1;
    set_addr(24'h200); exp_in(2, 24'h200, 0, 2);
    issue(enc(0, 0, 0, 3'd0, 3'd2, 8'd2)); wait_idle();
    end_check("R6 step zero end regs", 24'h200, 0);
    chk("R5 RAM2 holds read data", 64'(mem[2][1]), 64'hC300_0200);
    rdy_mode = 1'b0;

    // R9 R6: narrow bus, step code 3 (4), two words from RAM0
    narrow_bus = 1'b1;
    set_addr(24'h300); exp_out(0, 24'h300, 4, 2, 1);
    issue(enc(0, 0, 1, 3'd3, 3'd0, 8'd2)); wait_idle();
    end_check("R9 narrow end regs", 24'h310, 0);
    chk("R9 narrow has no step error", 64'(step_err), 64'd0);
    narrow_bus = 1'b0;

    // R8: wide bus with step code 3 -> error, step 1
    set_addr(24'h400); exp_out(3, 24'h400, 1, 2, 0);
    issue(enc(0, 0, 1, 3'd3, 3'd3, 8'd2));
    chk("R8 step error raised", 64'(step_err), 64'd1);
    wait_idle();
    end_check("R8 wide clamp end regs", 24'h402, 0);
    chk("R8 step error held", 64'(step_err), 64'd1);

    // R11: hold mode, outbound two words
    set_addr(24'h500); exp_out(0, 24'h500, 1, 2, 0);
    issue(enc(1, 0, 1, 3'd1, 3'd0, 8'd2));
    chk("R8 step error cleared on start", 64'(step_err), 64'd0);
    wait_idle();
    end_check("R11 hold restores regs", 24'h500, 2);

    // R4: indirect count from RAM3 with post-increment
    @(negedge clk); mem[3][ptr[3] % 16] = 32'd2;
    set_addr(24'h600); exp_ptr.push_back(4'b1000); exp_out(1, 24'h600, 1, 2, 0);
    issue(enc(0, 1, 1, 3'd1, 3'd1, 8'b0000_0111)); wait_idle();
    end_check("R4 indirect count end regs", 24'h602, 0);

    // R4: indirect count from RAM2, no increment
    @(negedge clk); mem[2][ptr[2] % 16] = 32'd1;
    set_addr(24'h680); exp_out(0, 24'h680, 1, 1, 0);
    issue(enc(0, 1, 1, 3'd1, 3'd0, 8'b0000_0010)); wait_idle();
    end_check("R4 no increment end regs", 24'h681, 0);

    // R7: short form, step code 111 -> step 1, program RAM target
    @(negedge clk); mem[0][ptr[0] % 16] = 32'd2;
    set_addr(24'h700); exp_in(4, 24'h700, 1, 2);
    issue(enc(0, 1, 0, 3'd7, 3'd4, 8'b0000_0000)); wait_idle();
    end_check("R7 short form end regs", 24'h702, 0);
    chk("R7 R8 no step error in short form", 64'(step_err), 64'd0);

    // R3: zero immediate count
    set_addr(24'h800);
    issue(enc(0, 0, 1, 3'd1, 3'd0, 8'd0)); #1;
    chk("R3 busy during closing cycle", 64'(busy), 64'd1);
    @(negedge clk); #1;
    chk("R3 busy falls after zero count", 64'(busy), 64'd0);
    end_check("R3 zero count regs", 24'h800, 0);

    // R1: foreign opcode ignored
    issue(32'hD000_1003); #1;
    chk("R1 foreign opcode ignored", 64'(busy), 64'd0);
    @(negedge clk); #1;
    chk("R1 still idle", 64'(busy), 64'd0);

    // R12 R13 R1: ready held low, extra instruction while busy, forced stop
    rdy_force = 1'b1; rdy_val = 1'b0;
    set_addr(24'hA00); exp_out(2, 24'hA00, 1, 1, 0);
    issue(enc(0, 0, 1, 3'd1, 3'd2, 8'd5));
    repeat (3) @(negedge clk); #1;
    chk("R12 beat held", {39'd0, ext_valid, ext_addr}, {39'd1, 24'hA00});
    issue(enc(0, 0, 1, 3'd1, 3'd1, 8'd4));
    @(negedge clk); force_stop = 1'b1;
    @(negedge clk); force_stop = 1'b0; rdy_force = 1'b0;
    wait_idle();
    end_check("R13 forced stop regs", 24'hA01, 4);
    repeat (2) @(negedge clk); #1;
    chk("R1 instruction while busy ignored", 64'(busy), 64'd0);

    // R13: end-of-transfer strobe on an inbound transfer
    set_addr(24'hB00); exp_in(1, 24'hB00, 0, 1);
    issue(enc(0, 0, 0, 3'd0, 3'd1, 8'd4));
    ext_end = 1'b1;
    @(negedge clk); ext_end = 1'b0;
    wait_idle();
    end_check("R13 end strobe regs", 24'hB00, 3);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule